// File: doc/BRIEF.md
# Pin Activity Event Generator

This block watches a small vector of pins that are already synchronous to its clock and keeps an activity counter for each pin. Each pin is set up on its own to count either the clock cycles it spends high or its rising edges. Whenever a counter holds a non-zero value, a round-robin scan picks that pin. The pin's whole count moves into a single egress message, together with an event index configured for that pin, and the counter starts again from zero.

Messages leave on one valid/ready lane. The count moves from a pin counter into the egress register at the moment that register is empty, or is being emptied in the same cycle. Once valid rises, the message is fixed: valid, index and count stay as they are until the consumer takes the message by holding ready high on a clock edge. While the consumer applies back-pressure, events keep piling up in the pin counters. Each counter stops at its maximum and does not wrap. A plain write port sets each pin's counting mode and its event index.

Top module: `pin_event_gen`

## Requirements
- R1: After reset, ev_valid is low, every counter is zero, every pin is in level mode, and every pin's event index is 0.
- R2: In level mode (cfg_edge = 0), a pin's count goes up by one on each clock edge at which the pin is sampled high.
- R3: In edge mode (cfg_edge = 1), a pin's count goes up by one on each clock edge at which the pin is sampled high and was sampled low at the edge before. The earlier sample is taken as low right after reset.
- R4: A clock edge with cfg_we high stores cfg_edge as the mode and cfg_index as the event index of pin cfg_pin. Each pin's setting applies only to that pin.
- R5: A message carries the pin's configured index in ev_index and the pin's whole accumulated count in ev_count. ev_count is never 0. When the count is moved into the message, the pin's counter clears, so no count is sent twice.
- R6: A count that reaches 2^CNT_W-1 (255) stays there, whatever further activity occurs, until it is sent.
- R7: If a pin's count would go up on the same edge that moves its count into the egress register, that increment is kept in the counter. No event is lost.
- R8: Among pins with non-zero counts, the next message goes to the first pin above the one last served, wrapping from 7 to 0. After reset, pin 0 comes first.
- R9: A message is taken only on an edge where ev_valid and ev_ready are both high. While ev_ready is low, ev_valid stays high and ev_index and ev_count hold steady.
- R10: If other pins are pending when a message is taken, the next message appears in the very next cycle, so one message can move per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | NPINS | Pin levels, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | SEL_W | Pin selected by the write |
| cfg_edge | input | 1 | Mode to write: 1 = rising-edge, 0 = level |
| cfg_index | input | IDX_W | Event index to write |
| ev_valid | output | 1 | Egress message present |
| ev_ready | input | 1 | Consumer accepts the message |
| ev_index | output | IDX_W | Event index of the message |
| ev_count | output | CNT_W | Accumulated count of the message |

## Verification
Two things can fall on one pin in the same clock edge: the pin's counter moving into the egress register, and a fresh increment of that counter. To provoke this, one pin is held high in level mode and a second pin toggles in edge mode. At the same time, ev_ready follows an irregular pattern, so transfers keep landing on cycles with new activity. The test is judged by totals. Adding up the ev_count of every accepted message for each pin must give exactly the number of high cycles, or rising edges, that the bench drove.

// File: rtl/pev_pkg.sv
package pev_pkg;
  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_EDGE  = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pev_pin_counter.sv
module pev_pin_counter
  import pev_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  cnt_mode_e        mode,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic pin_q;
  logic hit;

  // one increment per high cycle, or per low-to-high step
  always_comb begin
    if (mode == MODE_EDGE) hit = pin & ~pin_q;
    else                   hit = pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      count <= '0;
    end else begin
      pin_q <= pin;
      if (take)
        count <= hit ? CNT_W'(1) : '0;   // a same-cycle increment survives
      else if (hit && count != CNT_MAX)
        count <= count + 1'b1;
    end
  end

  assign pending = (count != '0);
endmodule

// File: rtl/pev_rr_arb.sv
module pev_rr_arb #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     gnt,
  output logic [SEL_W-1:0] gnt_idx,
  output logic             any
);
  logic [SEL_W-1:0] last;
  logic             found;

  // scan upward from the slot after the last one served
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!found && req[j]) begin
        gnt[j]  = 1'b1;
        gnt_idx = SEL_W'(j);
        found   = 1'b1;
      end
    end
  end

  assign any = |req;

  always_ff @(posedge clk) begin
    if (!rst_n)       last <= SEL_W'(N - 1);
    else if (advance) last <= gnt_idx;
  end
endmodule

// File: rtl/pin_event_gen.sv
module pin_event_gen
  import pev_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int CNT_W = 8,
  parameter int IDX_W = 10,
  localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_pin,
  input  logic             cfg_edge,
  input  logic [IDX_W-1:0] cfg_index,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [IDX_W-1:0] ev_index,
  output logic [CNT_W-1:0] ev_count
);
  cnt_mode_e        mode_r [NPINS];
  logic [IDX_W-1:0] idx_r  [NPINS];
  logic [CNT_W-1:0] cnt    [NPINS];
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] gnt;
  logic [NPINS-1:0] take;
  logic [SEL_W-1:0] gnt_idx;
  logic             any_pend;
  logic             load;

  // per-pin setup
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) begin
        mode_r[i] <= MODE_LEVEL;
        idx_r[i]  <= '0;
      end
    end else if (cfg_we && int'(cfg_pin) < NPINS) begin
      mode_r[cfg_pin] <= cfg_edge ? MODE_EDGE : MODE_LEVEL;
      idx_r[cfg_pin]  <= cfg_index;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pev_pin_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pins[g]),
      .mode    (mode_r[g]),
      .take    (take[g]),
      .count   (cnt[g]),
      .pending (pend[g])
    );
  end

  pev_rr_arb #(.N(NPINS), .SEL_W(SEL_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pend),
    .advance (load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_pend)
  );

  // egress slot refills when empty or draining this cycle
  assign load = any_pend && (!ev_valid || ev_ready);
  assign take = gnt & {NPINS{load}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_index <= '0;
      ev_count <= '0;
    end else if (load) begin
      ev_valid <= 1'b1;
      ev_index <= idx_r[gnt_idx];
      ev_count <= cnt[gnt_idx];
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pev_chk.sv
module pev_chk #(
  parameter int NPINS = 8,
  parameter int CNT_W = 8,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [IDX_W-1:0] ev_index,
  input logic [CNT_W-1:0] ev_count,
  input logic [NPINS-1:0] req,
  input logic [NPINS-1:0] gnt
);
  // R9
  held_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_index) && $stable(ev_count));

  // R5
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_count != '0);

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R8
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R8
  pending_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

bind pin_event_gen pev_chk #(.NPINS(NPINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_valid (ev_valid),
  .ev_ready (ev_ready),
  .ev_index (ev_index),
  .ev_count (ev_count),
  .req      (pend),
  .gnt      (gnt)
);

// File: tb/tb_pin_event_gen.sv
`timescale 1ns/1ps
module tb_pin_event_gen;
  localparam int NP = 8;
  localparam int CW = 8;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_pin = '0;
  logic          cfg_edge = 1'b0;
  logic [IW-1:0] cfg_index = '0;
  logic          ev_ready = 1'b0;
  logic          ev_valid;
  logic [IW-1:0] ev_index;
  logic [CW-1:0] ev_count;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;
  logic [15:0] lfsr = 16'hACE1;
  int idx_cfg [NP];

  pin_event_gen dut (
    .clk(clk), .rst_n(rst_n), .pins(pins),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_edge(cfg_edge), .cfg_index(cfg_index),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_index(ev_index), .ev_count(ev_count)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cfg_write(input int p, input bit e, input int ix);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = 3'(p); cfg_edge = e; cfg_index = IW'(ix);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lfsr_step();
    lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  endtask

  // one sweep: pin 7 fills the egress slot, pins 0..6 accumulate, then drain
  task automatic run_round(input logic [7:0] mask, input int len,
                           input logic [6:0] force_m, input int base);
    int expc [NP];
    bit prev [NP];
    logic [6:0] pat;
    for (int i = 0; i < NP; i++) begin
      idx_cfg[i] = (base + i * 37) % 1024;
      cfg_write(i, mask[i], idx_cfg[i]);   // R4
      expc[i] = 0;
      prev[i] = 1'b0;
    end
    ev_ready = 1'b0;
    @(negedge clk); pins[7] = 1'b1;
    @(negedge clk); pins[7] = 1'b0;
    repeat (3) @(negedge clk);
    chk(ev_valid == 1'b1, "R5 valid after pin7 pulse", int'(ev_valid), 1);
    chk(int'(ev_index) == idx_cfg[7], "R5 pin7 index", int'(ev_index), idx_cfg[7]);
    chk(int'(ev_count) == 1, "R5 pin7 count", int'(ev_count), 1);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      // R9: held message under back-pressure
      chk(ev_valid && int'(ev_index) == idx_cfg[7] && int'(ev_count) == 1,
          "R9 hold", int'(ev_count), 1);
      lfsr_step();
      pat = (lfsr[6:0] ^ lfsr[13:7]) | force_m;
      pins = {1'b0, pat};
      for (int i = 0; i < 7; i++) begin
        if (mask[i]) begin
          if (pat[i] && !prev[i] && expc[i] < 255) expc[i]++;
        end else begin
          if (pat[i] && expc[i] < 255) expc[i]++;
        end
        prev[i] = pat[i];
      end
    end
    @(negedge clk); pins = '0;
    @(negedge clk);
    ev_ready = 1'b1;
    chk(ev_valid && int'(ev_index) == idx_cfg[7] && int'(ev_count) == 1,
        "R9 pin7 message still present", int'(ev_count), 1);
    for (int i = 0; i < 7; i++) begin
      if (expc[i] != 0) begin
        @(negedge clk);
        chk(ev_valid == 1'b1, "R10 back-to-back valid", int'(ev_valid), 1);
        chk(int'(ev_index) == idx_cfg[i], "R8 round-robin order index", int'(ev_index), idx_cfg[i]);
        if (expc[i] == 255)
          chk(int'(ev_count) == expc[i], "R6 saturated count", int'(ev_count), expc[i]);
        else if (mask[i])
          chk(int'(ev_count) == expc[i], "R3 edge count", int'(ev_count), expc[i]);
        else
          chk(int'(ev_count) == expc[i], "R2 level count", int'(ev_count), expc[i]);
      end
    end
    @(negedge clk);
    chk(ev_valid == 1'b0, "R5 no extra message", int'(ev_valid), 0);
    ev_ready = 1'b0;
  endtask

  task automatic run_overlap();
    int sum0, sum1, bad;
    sum0 = 0; sum1 = 0; bad = 0;
    cfg_write(0, 1'b0, 5);
    cfg_write(1, 1'b1, 9);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      pins = '0;
      pins[0] = 1'b1;
      pins[1] = ((c % 4) < 2);
      ev_ready = ((c % 3) != 0);
      #1;
      if (ev_valid && ev_ready) begin
        if (int'(ev_index) == 5) sum0 += int'(ev_count);
        else if (int'(ev_index) == 9) sum1 += int'(ev_count);
        else bad++;
      end
    end
    @(negedge clk);
    pins = '0;
    ev_ready = 1'b1;
    for (int c = 0; c < 12; c++) begin
      #1;
      if (ev_valid) begin
        if (int'(ev_index) == 5) sum0 += int'(ev_count);
        else if (int'(ev_index) == 9) sum1 += int'(ev_count);
        else bad++;
      end
      @(negedge clk);
    end
    ev_ready = 1'b0;
    chk(sum0 == 200, "R7 level total across transfers", sum0, 200);
    chk(sum1 == 50, "R7 edge total across transfers", sum1, 50);
    chk(bad == 0, "R5 unexpected index", bad, 0);
    chk(ev_valid == 1'b0, "R9 drained", int'(ev_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_valid == 1'b0, "R1 valid low after reset", int'(ev_valid), 0);
    repeat (4) @(negedge clk);
    chk(ev_valid == 1'b0, "R1 idle counters stay empty", int'(ev_valid), 0);
    pins[3] = 1'b1;
    @(negedge clk); pins[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk(ev_valid == 1'b1, "R1 message from default setup", int'(ev_valid), 1);
    chk(ev_index == '0, "R1 default index", int'(ev_index), 0);
    chk(int'(ev_count) == 1, "R1 default level count", int'(ev_count), 1);
    ev_ready = 1'b1;
    @(negedge clk);
    ev_ready = 1'b0;
    chk(ev_valid == 1'b0, "R9 taken on valid and ready", int'(ev_valid), 0);

    run_round(8'h00, 60, 7'h00, 100);
    run_round(8'h7F, 60, 7'h00, 300);
    run_round(8'h55, 100, 7'h00, 520);
    run_round(8'h2A, 300, 7'h0F, 700);
    run_round(8'h00, 400, 7'h00, 11);
    run_overlap();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule